// File: doc/BRIEF.md
# Cartridge Bank Switching Register File

This block sits on the cartridge side of an 8-bit console and turns CPU register writes in the upper half of the address map into bank numbers for the program ROM and the character ROM. It holds two switchable 8 KB program banks and eight switchable 1 KB character banks. The upper two 8 KB CPU windows are fixed to the last two program banks. Each cycle it combines the stored bank numbers with a CPU read address and a video address, and it drives the physical ROM addresses that the program and character storage, which sit outside the block, consume.

Each character bank number is eight bits wide. It is loaded as two four-bit halves through separate register addresses. The write decode looks only at CPU address bits 15:12 and 3:2, so the remaining address bits select aliases of the same register. The number of program banks and the number of character banks are parameters. Both must be powers of two, and stored bank numbers wrap modulo those counts when they are applied.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with `wr_addr[15:12] == 4'h8` stores all eight bits of `wr_data` as the bank for CPU window 0x8000–0x9FFF, applied modulo `PRG_BANKS`.
- R2: A write with `wr_addr[15:12] == 4'hA` stores all eight bits of `wr_data` as the bank for CPU window 0xA000–0xBFFF, applied modulo `PRG_BANKS`.
- R3: CPU window 0xC000–0xDFFF (`cpu_addr[14:13] == 2'b10`) always uses program bank `PRG_BANKS-2`, and window 0xE000–0xFFFF (`2'b11`) always uses bank `PRG_BANKS-1`.
- R4: `prg_phys` equals the bank of the window selected by `cpu_addr[14:13]`, times 8192, plus `cpu_addr[12:0]`.
- R5: Character register n (0..7) is written at high nibble `4'hB + n/2` of `wr_addr[15:12]`. `wr_addr[3]` selects the odd register of the pair, and `wr_addr[2]` selects the high nibble (1) or the low nibble (0).
- R6: A character write takes only `wr_data[3:0]` into the addressed nibble and leaves the other nibble of that register unchanged.
- R7: After a synchronous active-low reset, character register n holds n, the 0x8000 window uses program bank 0 and the 0xA000 window uses program bank 1.
- R8: `chr_phys` equals the character register picked by `vid_addr[12:10]`, taken modulo `CHR_BANKS`, times 1024, plus `vid_addr[9:0]`.
- R9: Writes with `wr_addr[15] == 0`, writes with `wr_addr[15:12] == 4'hF`, and cycles with `wr_en` low change no bank.
- R10: Address bits 11:4 and 1:0 do not take part in the decode, so any value of these bits reaches the same register.
- R11: A write takes effect on the rising clock edge that samples it, and the physical addresses reflect it from then on without further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 15 | CPU read address bits 14:0 inside 0x8000–0xFFFF |
| prg_phys | output | $clog2(PRG_BANKS)+13 | Physical program-ROM byte address |
| vid_addr | input | 13 | Video pattern address |
| chr_phys | output | $clog2(CHR_BANKS)+10 | Physical character-ROM byte address |

## Verification
The bench targets nibble merging. A design that overwrote the whole byte, or took the wrong data nibble, would corrupt the half that was not written. It also drives aliased addresses with random bits in the ignored positions. A decode that looked at too many bits would miss these writes, and one that looked at too few would also respond to the 0xF range or to addresses below 0x8000. It checks the fixed upper windows and the modulo wrap of out-of-range program bank numbers, where an off-by-one in the last-bank arithmetic or a missing wrap would point into the wrong 8 KB. Finally, it samples right after a write, which exposes an extra pipeline stage.

// File: rtl/cbk_pkg.sv
// Shared types for the cartridge bank controller.
// Assumes eight character slots and eight-bit bank register fields.
package cbk_pkg;
    localparam int CHR_SLOTS = 8;
    localparam int REG_W     = 8;

    // One decoded write: which register and which half is targeted.
    typedef struct packed {
        logic [1:0]           prg_we;
        logic [CHR_SLOTS-1:0] chr_we;
        logic                 chr_hi;
    } cbk_wr_t;
endpackage

// File: rtl/cbk_wr_decode.sv
// Write decoder: masks the CPU write address to bits 15:12 and 3:2 and
// yields one-hot write enables. Assumes one write per wr_en cycle.
module cbk_wr_decode
    import cbk_pkg::*;
(
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    output cbk_wr_t     dec
);
    // Map the masked address to a register target.
    always_comb begin
        dec = '0;
        if (wr_en) begin
            casez (wr_addr & 16'hF00C)
                16'h8???: dec.prg_we = 2'b01;
                16'hA???: dec.prg_we = 2'b10;
                16'hB000: begin dec.chr_we = 8'h01; dec.chr_hi = 1'b0; end
                16'hB004: begin dec.chr_we = 8'h01; dec.chr_hi = 1'b1; end
                16'hB008: begin dec.chr_we = 8'h02; dec.chr_hi = 1'b0; end
                16'hB00C: begin dec.chr_we = 8'h02; dec.chr_hi = 1'b1; end
                16'hC000: begin dec.chr_we = 8'h04; dec.chr_hi = 1'b0; end
                16'hC004: begin dec.chr_we = 8'h04; dec.chr_hi = 1'b1; end
                16'hC008: begin dec.chr_we = 8'h08; dec.chr_hi = 1'b0; end
                16'hC00C: begin dec.chr_we = 8'h08; dec.chr_hi = 1'b1; end
                16'hD000: begin dec.chr_we = 8'h10; dec.chr_hi = 1'b0; end
                16'hD004: begin dec.chr_we = 8'h10; dec.chr_hi = 1'b1; end
                16'hD008: begin dec.chr_we = 8'h20; dec.chr_hi = 1'b0; end
                16'hD00C: begin dec.chr_we = 8'h20; dec.chr_hi = 1'b1; end
                16'hE000: begin dec.chr_we = 8'h40; dec.chr_hi = 1'b0; end
                16'hE004: begin dec.chr_we = 8'h40; dec.chr_hi = 1'b1; end
                16'hE008: begin dec.chr_we = 8'h80; dec.chr_hi = 1'b0; end
                16'hE00C: begin dec.chr_we = 8'h80; dec.chr_hi = 1'b1; end
                default:  dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/cbk_bank_regs.sv
// Bank register storage: two full-byte program banks and eight character
// banks written a nibble at a time. Synchronous active-low reset.
module cbk_bank_regs
    import cbk_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  cbk_wr_t                         dec,
    input  logic [REG_W-1:0]                wr_data,
    output logic [1:0][REG_W-1:0]           prg_q,
    output logic [CHR_SLOTS-1:0][REG_W-1:0] chr_q
);
    for (genvar p = 0; p < 2; p++) begin : g_prg
        // Load a program bank from the full data byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prg_q[p] <= REG_W'(p);
            else if (dec.prg_we[p])
                prg_q[p] <= wr_data;
        end
    end

    for (genvar c = 0; c < CHR_SLOTS; c++) begin : g_chr
        // Merge the low data nibble into one half of a character bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chr_q[c] <= REG_W'(c);
            else if (dec.chr_we[c]) begin
                if (dec.chr_hi)
                    chr_q[c] <= {wr_data[3:0], chr_q[c][3:0]};
                else
                    chr_q[c] <= {chr_q[c][7:4], wr_data[3:0]};
            end
        end
    end
endmodule

// File: rtl/cbk_prg_map.sv
// Program address former: picks the bank of one of four 8 KB CPU windows,
// two switchable and two fixed at the end of ROM. PRG_BANKS is a power of two.
module cbk_prg_map
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int ADDR_W   = BANK_W + 13
)(
    input  logic [1:0][REG_W-1:0] prg_q,
    input  logic [14:0]           cpu_addr,
    output logic [ADDR_W-1:0]     prg_phys
);
    localparam logic [BANK_W-1:0] SECOND_LAST = BANK_W'(PRG_BANKS - 2);
    localparam logic [BANK_W-1:0] LAST        = BANK_W'(PRG_BANKS - 1);

    logic [REG_W-1:0]  raw_bank;
    logic [BANK_W-1:0] bank;

    // Choose the window bank and wrap switchable numbers into range.
    always_comb begin
        raw_bank = (cpu_addr[13]) ? prg_q[1] : prg_q[0];
        case (cpu_addr[14:13])
            2'b10:   bank = SECOND_LAST;
            2'b11:   bank = LAST;
            default: bank = BANK_W'(32'(raw_bank) % PRG_BANKS);
        endcase
        prg_phys = {bank, cpu_addr[12:0]};
    end
endmodule

// File: rtl/cbk_chr_map.sv
// Character address former: video bits 12:10 pick one of eight 1 KB banks.
// CHR_BANKS is a power of two; bank numbers wrap modulo it.
module cbk_chr_map
    import cbk_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    localparam int BANK_W   = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int ADDR_W   = BANK_W + 10
)(
    input  logic [CHR_SLOTS-1:0][REG_W-1:0] chr_q,
    input  logic [12:0]                     vid_addr,
    output logic [ADDR_W-1:0]               chr_phys
);
    logic [REG_W-1:0] raw_bank;

    // Select the slot register and append the in-bank offset.
    always_comb begin
        raw_bank = chr_q[vid_addr[12:10]];
        chr_phys = {BANK_W'(32'(raw_bank) % CHR_BANKS), vid_addr[9:0]};
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
// Top level of the cartridge bank controller: decodes CPU register writes,
// keeps the bank numbers and forms both physical ROM addresses combinationally.
// Assumes cpu_addr is only meaningful for reads inside 0x8000-0xFFFF.
module cart_bank_ctrl
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 256,
    localparam int PRG_W    = ((PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1) + 13,
    localparam int CHR_W    = ((CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1) + 10
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [14:0]       cpu_addr,
    output logic [PRG_W-1:0]  prg_phys,
    input  logic [12:0]       vid_addr,
    output logic [CHR_W-1:0]  chr_phys
);
    cbk_wr_t                         dec;
    logic [1:0][REG_W-1:0]           prg_q;
    logic [CHR_SLOTS-1:0][REG_W-1:0] chr_q;

    cbk_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .dec     (dec)
    );

    cbk_bank_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wr_data (wr_data),
        .prg_q   (prg_q),
        .chr_q   (chr_q)
    );

    cbk_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .prg_q    (prg_q),
        .cpu_addr (cpu_addr),
        .prg_phys (prg_phys)
    );

    cbk_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .chr_q    (chr_q),
        .vid_addr (vid_addr),
        .chr_phys (chr_phys)
    );
endmodule

// File: rtl/cbk_checker.sv
// Property checker for cart_bank_ctrl, attached by bind. Observes ports and
// the bank registers that the storage module drives.
module cbk_checker
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int PRG_W    = BANK_W + 13
)(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [15:0]                     wr_addr,
    input logic [7:0]                      wr_data,
    input logic [14:0]                     cpu_addr,
    input logic [PRG_W-1:0]                prg_phys,
    input logic [1:0][REG_W-1:0]           prg_q,
    input logic [CHR_SLOTS-1:0][REG_W-1:0] chr_q
);
    AST_PRG0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr[15:12]) == 4'h8)
        |-> prg_q[0] == $past(wr_data)); // R1

    AST_PRG1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr[15:12]) == 4'hA)
        |-> prg_q[1] == $past(wr_data)); // R2

    AST_FIXED_WINDOW_C: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b10) |-> prg_phys[PRG_W-1:13] == BANK_W'(PRG_BANKS - 2)); // R3

    AST_FIXED_WINDOW_E: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> prg_phys[PRG_W-1:13] == BANK_W'(PRG_BANKS - 1)); // R3

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> prg_phys[12:0] == cpu_addr[12:0]); // R4

    AST_CHR0_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr[15:12]) == 4'hB && $past(wr_addr[3:2]) == 2'b00)
        |-> chr_q[0] == {$past(chr_q[0][7:4]), $past(wr_data[3:0])}); // R6

    AST_CHR7_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr[15:12]) == 4'hE && $past(wr_addr[3:2]) == 2'b11)
        |-> chr_q[7] == {$past(wr_data[3:0]), $past(chr_q[7][3:0])}); // R5

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (prg_q[0] == 8'd0 && prg_q[1] == 8'd1 && chr_q[5] == 8'd5 && chr_q[7] == 8'd7)); // R7

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(wr_en) || !$past(wr_addr[15]) || $past(wr_addr[15:12]) == 4'hF))
        |-> (prg_q == $past(prg_q) && chr_q == $past(chr_q))); // R9
endmodule

bind cart_bank_ctrl cbk_checker #(.PRG_BANKS(PRG_BANKS)) u_cbk_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cpu_addr (cpu_addr),
    .prg_phys (prg_phys),
    .prg_q    (prg_q),
    .chr_q    (chr_q)
);

// File: tb/cart_bank_ctrl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random writes,
// compared against a behavioural model of the register file.
module cart_bank_ctrl_tb_top;
    localparam int PRG_BANKS = 32;
    localparam int CHR_BANKS = 256;
    localparam int PRG_W     = 18;
    localparam int CHR_W     = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [14:0]       cpu_addr = '0;
    logic [12:0]       vid_addr = '0;
    logic [PRG_W-1:0]  prg_phys;
    logic [CHR_W-1:0]  chr_phys;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_prg [2];
    logic [7:0] m_chr [8];

    cart_bank_ctrl #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .prg_phys(prg_phys),
        .vid_addr(vid_addr), .chr_phys(chr_phys)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL R11 watchdog: actual %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [PRG_W-1:0] exp_prg(input logic [14:0] a);
        int bank;
        case (a[14:13])
            2'd0: bank = m_prg[0] % PRG_BANKS;
            2'd1: bank = m_prg[1] % PRG_BANKS;
            2'd2: bank = PRG_BANKS - 2;
            default: bank = PRG_BANKS - 1;
        endcase
        return PRG_W'(bank * 8192 + a[12:0]);
    endfunction

    function automatic logic [CHR_W-1:0] exp_chr(input logic [12:0] v);
        return CHR_W'((m_chr[v[12:10]] % CHR_BANKS) * 1024 + v[9:0]);
    endfunction

    task automatic model_reset();
        m_prg[0] = 8'd0;
        m_prg[1] = 8'd1;
        for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        int idx;
        if (!a[15]) return;
        if (a[15:12] == 4'h8) m_prg[0] = d;
        else if (a[15:12] == 4'hA) m_prg[1] = d;
        else if (a[15:12] >= 4'hB && a[15:12] <= 4'hE) begin
            idx = (int'(a[15:12]) - 11) * 2 + int'(a[3]);
            if (a[2]) m_chr[idx][7:4] = d[3:0];
            else      m_chr[idx][3:0] = d[3:0];
        end
    endtask

    // Drive one write strobe for a single cycle.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_prg(input logic [14:0] a, input string req);
        logic [PRG_W-1:0] e;
        cpu_addr = a; #1;
        e = exp_prg(a);
        checks++;
        if (prg_phys !== e) begin
            errors++;
            $display("FAIL %s prg addr %h: actual %h expected %h", req, a, prg_phys, e);
        end
    endtask

    task automatic chk_chr(input logic [12:0] v, input string req);
        logic [CHR_W-1:0] e;
        vid_addr = v; #1;
        e = exp_chr(v);
        checks++;
        if (chr_phys !== e) begin
            errors++;
            $display("FAIL %s chr addr %h: actual %h expected %h", req, v, chr_phys, e);
        end
    endtask

    task automatic chk_all(input string req);
        for (int s = 0; s < 4; s++) chk_prg(15'((s << 13) | ($urandom & 16'h1FFF)), req);
        for (int s = 0; s < 8; s++) chk_chr(13'((s << 10) | ($urandom & 16'h3FF)), req);
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R7");

        // R1 / R2: full-byte program loads, including an out-of-range number.
        do_write(16'h8000, 8'h13); chk_prg(15'h0123, "R1");
        do_write(16'h9FFF, 8'hE5); chk_prg(15'h1ABC, "R1");
        do_write(16'hA000, 8'h07); chk_prg(15'h2001, "R2");
        do_write(16'hB3F7 & 16'hAFFF | 16'hA000, 8'hFF); chk_prg(15'h3FFF, "R2");
        // R3: fixed windows stay put after switchable writes.
        chk_prg(15'h4000, "R3");
        chk_prg(15'h7FFF, "R3");
        chk_prg(15'h5555, "R4");

        // R5 / R6: nibble writes to pairs, checking the kept half.
        do_write(16'hB000, 8'hFA); chk_chr(13'h0005, "R6");
        do_write(16'hB004, 8'h3C); chk_chr(13'h0005, "R5");
        do_write(16'hC00C, 8'h59); chk_chr(13'h0FFF, "R5");
        do_write(16'hE008, 8'h06); chk_chr(13'h1C10, "R6");
        do_write(16'hE00C, 8'h0B); chk_chr(13'h1C10, "R5");
        chk_chr(13'h0800, "R8");

        // R10: aliases with ignored address bits set.
        do_write(16'hDFF3, 8'h0E); chk_chr(13'h1400, "R10");
        do_write(16'hD7F1, 8'h0D); chk_chr(13'h1000, "R10");

        // R9: writes that must not touch anything.
        do_write(16'h7004, 8'h77); chk_all("R9");
        do_write(16'hF000, 8'h0F); chk_all("R9");
        do_write(16'h0000, 8'hFF); chk_all("R9");
        @(negedge clk); wr_addr = 16'h8000; wr_data = 8'h1F;
        @(negedge clk); chk_prg(15'h0000, "R9");

        // R11: value visible right after the capturing edge.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h09;
        @(posedge clk); model_write(16'h8000, 8'h09);
        #1; wr_en = 1'b0;
        chk_prg(15'h0042, "R11");

        // Random mix of writes and reads.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if (($urandom % 4) != 0) a[15] = 1'b1;
            do_write(a, 8'($urandom));
            chk_prg(15'($urandom), "R4");
            chk_chr(13'($urandom), "R8");
        end

        // R7: reset after random traffic restores defaults.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        chk_all("R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule